// File: doc/BRIEF.md
# PCM voice-channel serial port

This block is a full-duplex serial port for one voice channel. It moves 8-bit companded samples between parallel words and a pair of serial lines. On the transmit side it shifts a parallel sample out. On the receive side it assembles a byte from the incoming line and presents it in parallel, with a one-cycle valid strobe. All of its logic runs on the master clock. The data clocks and frame syncs are taken in as levels synchronous to that clock, and their edges are detected inside the block.

Two framing modes are available. In fixed-rate mode the master clock itself sets the bit rate. A frame starts on the rising edge of frame sync. A sync pulse two clocks long, rather than one, marks a signaling frame. In variable-rate mode each direction uses its own data clock, and the frame-sync line becomes a time-slot enable. Bits move only while that enable is high. Each direction also runs a timer that puts it into standby after a long frame-sync absence. The length of that absence is scaled to the master-clock rate named by a rate-select input.

Top module: `pcm_voice_port`

## Requirements
- R1: Fixed mode (fixed_mode=1). On the first clock where tx_fs is sampled high after being low, the sample is loaded. tx_sd then carries it MSB first, one bit per clock, starting the cycle after that edge. tx_oe is high for exactly those 8 cycles and low otherwise.
- R2: Fixed mode. The receive direction captures rx_sd on the 8 clock edges that follow the tx-style rising-edge detection on rx_fs, MSB first. After the last capture, rx_valid pulses for one cycle with the byte on rx_sample. A transmit line looped back to rx_sd is therefore received unchanged.
- R3: Fixed mode. If rx_fs is still high on the edge after its rising edge (a pulse two clocks long), rx_sig is 1 alongside rx_valid. For a one-clock pulse rx_sig is 0. rx_sig holds its value until the next rx_valid.
- R4: Variable mode (fixed_mode=0). Each rising edge of tx_dclk that is seen while tx_fs is high drives the next bit, MSB first. The first such edge loads the sample. A ninth rising edge in the same slot releases tx_oe, and tx_oe goes low whenever tx_fs is low.
- R5: Variable mode. Each falling edge of rx_dclk that is seen while rx_fs is high captures one bit. After the eighth, one rx_valid pulse is given. Edges seen while rx_fs is low, and edges after the eighth in the same slot, capture nothing. Dropping rx_fs part-way through a slot discards the partial byte.
- R6: In variable mode, rx_sig is 0 with every rx_valid.
- R7: fixed_mode=1 selects fixed-rate framing, in which tx_dclk and rx_dclk have no effect. fixed_mode=0 selects variable-rate framing.
- R8: When a frame sync has been low for L consecutive clocks, that direction's standby flag goes high and stays high while the sync stays low. L depends on clk_sel: 0 gives LIM_1536, 1 gives LIM_1544, and 2 or 3 give LIM_2048. The defaults are 300 ms at 1.536, 1.544 and 2.048 MHz.
- R9: Any clock with the frame sync high clears that direction's standby flag on the next cycle and restarts its timer.
- R10: The transmit and receive standby timers are independent. One flag going high or clearing does not change the other.
- R11: While rst is high, and on the cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fixed_mode | input | 1 | 1 selects fixed-rate framing, 0 selects variable-rate |
| clk_sel | input | 2 | Master-clock rate code for the standby timeout |
| tx_dclk | input | 1 | Transmit data clock (variable mode) |
| rx_dclk | input | 1 | Receive data clock (variable mode) |
| tx_fs | input | 1 | Transmit frame sync / slot enable |
| rx_fs | input | 1 | Receive frame sync / slot enable |
| tx_sample | input | 8 | Parallel sample to send |
| rx_sd | input | 1 | Serial receive line |
| tx_sd | output | 1 | Serial transmit line |
| tx_oe | output | 1 | Transmit line enable |
| rx_sample | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| rx_sig | output | 1 | Signaling-frame flag for the last byte |
| tx_standby | output | 1 | Transmit direction in standby |
| rx_standby | output | 1 | Receive direction in standby |

## Verification
All 256 byte values are sent through a loopback in both modes, alternating one- and two-clock sync pulses. This catches a reversed bit order, an off-by-one capture window, and a mislabelled signaling frame. In variable mode the bench toggles the data clocks with the enable low, adds a ninth data-clock edge to each slot, and aborts a slot part-way through. A design that shifted without its enable, overran the slot, or kept stale bits would emit extra strobes or a corrupted next byte. The standby timers are measured to the exact clock for every rate code while the opposite direction stays active. This exposes an off-by-one limit, a wrong code mapping, or timers that share state.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic [1:0] {
    RATE_1536   = 2'd0,
    RATE_1544   = 2'd1,
    RATE_2048   = 2'd2,
    RATE_2048_B = 2'd3
  } clk_rate_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fixed_mode,
  input  logic         dclk,
  input  logic         fs,
  input  logic [W-1:0] sample,
  output logic         sd,
  output logic         oe
);
  localparam int CNT_W = $clog2(W + 1);

  logic             dclk_q, fs_q;
  logic [CNT_W-1:0] cnt;
  logic [W-2:0]     shreg;
  logic             dclk_rise, fs_rise;

  assign dclk_rise = dclk & ~dclk_q;
  assign fs_rise   = fs & ~fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_q <= 1'b0;
      fs_q   <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      sd     <= 1'b0;
      oe     <= 1'b0;
    end else begin
      dclk_q <= dclk;
      fs_q   <= fs;
      if (fixed_mode) begin
        // master clock is the bit clock; sync rising edge opens the slot
        if (fs_rise) begin
          sd    <= sample[W-1];
          shreg <= sample[W-2:0];
          oe    <= 1'b1;
          cnt   <= CNT_W'(1);
        end else if (cnt != '0) begin
          if (cnt == CNT_W'(W)) begin
            oe  <= 1'b0;
            sd  <= 1'b0;
            cnt <= '0;
          end else begin
            sd    <= shreg[W-2];
            shreg <= {shreg[W-3:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
      end else begin
        // slot enable gates every shift
        if (!fs) begin
          oe  <= 1'b0;
          sd  <= 1'b0;
          cnt <= '0;
        end else if (dclk_rise) begin
          if (cnt == '0) begin
            sd    <= sample[W-1];
            shreg <= sample[W-2:0];
            oe    <= 1'b1;
            cnt   <= CNT_W'(1);
          end else if (cnt == CNT_W'(W)) begin
            oe <= 1'b0;
            sd <= 1'b0;
          end else begin
            sd    <= shreg[W-2];
            shreg <= {shreg[W-3:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fixed_mode,
  input  logic         dclk,
  input  logic         fs,
  input  logic         sd,
  output logic [W-1:0] data,
  output logic         valid,
  output logic         sig
);
  localparam int CNT_W = $clog2(W + 1);

  logic             dclk_q, fs_q;
  logic             busy, sig_pend;
  logic [CNT_W-1:0] cnt;
  logic [W-2:0]     acc;
  logic             dclk_fall, fs_rise;

  assign dclk_fall = ~dclk & dclk_q;
  assign fs_rise   = fs & ~fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_q   <= 1'b0;
      fs_q     <= 1'b0;
      busy     <= 1'b0;
      sig_pend <= 1'b0;
      cnt      <= '0;
      acc      <= '0;
      data     <= '0;
      valid    <= 1'b0;
      sig      <= 1'b0;
    end else begin
      dclk_q <= dclk;
      fs_q   <= fs;
      valid  <= 1'b0;
      if (fixed_mode) begin
        if (fs_rise) begin
          busy <= 1'b1;
          cnt  <= '0;
        end else if (busy) begin
          acc <= {acc[W-3:0], sd};
          cnt <= cnt + 1'b1;
          // sync still high one clock after its rise: signaling frame
          if (cnt == '0) sig_pend <= fs;
          if (cnt == CNT_W'(W - 1)) begin
            busy  <= 1'b0;
            valid <= 1'b1;
            data  <= {acc, sd};
            sig   <= sig_pend;
          end
        end
      end else begin
        busy <= 1'b0;
        if (!fs) begin
          cnt <= '0;
        end else if (dclk_fall && cnt != CNT_W'(W)) begin
          acc <= {acc[W-3:0], sd};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(W - 1)) begin
            valid <= 1'b1;
            data  <= {acc, sd};
            sig   <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pcm_standby_timer.sv
module pcm_standby_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fs,
  input  logic [CW-1:0] limit,
  output logic          standby
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      standby <= 1'b0;
    end else if (fs) begin
      cnt     <= '0;
      standby <= 1'b0;
    end else if (!standby) begin
      if (cnt == limit - 1'b1) standby <= 1'b1;
      else                     cnt     <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int W         = 8,
  parameter int LIM_1536  = 460800,
  parameter int LIM_1544  = 463200,
  parameter int LIM_2048  = 614400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fixed_mode,
  input  logic [1:0]   clk_sel,
  input  logic         tx_dclk,
  input  logic         rx_dclk,
  input  logic         tx_fs,
  input  logic         rx_fs,
  input  logic [W-1:0] tx_sample,
  input  logic         rx_sd,
  output logic         tx_sd,
  output logic         tx_oe,
  output logic [W-1:0] rx_sample,
  output logic         rx_valid,
  output logic         rx_sig,
  output logic         tx_standby,
  output logic         rx_standby
);
  localparam int unsigned LIM_MAX = max3(LIM_1536, LIM_1544, LIM_2048);
  localparam int CW = $clog2(LIM_MAX + 1);

  clk_rate_e     rate;
  logic [CW-1:0] limit;

  assign rate = clk_rate_e'(clk_sel);

  always_comb begin
    case (rate)
      RATE_1536: limit = CW'(LIM_1536);
      RATE_1544: limit = CW'(LIM_1544);
      default:   limit = CW'(LIM_2048);
    endcase
  end

  pcm_tx_framer #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .fixed_mode(fixed_mode), .dclk(tx_dclk), .fs(tx_fs),
    .sample(tx_sample), .sd(tx_sd), .oe(tx_oe)
  );

  pcm_rx_framer #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .fixed_mode(fixed_mode), .dclk(rx_dclk), .fs(rx_fs),
    .sd(rx_sd), .data(rx_sample), .valid(rx_valid), .sig(rx_sig)
  );

  pcm_standby_timer #(.CW(CW)) u_tx_stby (
    .clk(clk), .rst(rst), .fs(tx_fs), .limit(limit), .standby(tx_standby)
  );

  pcm_standby_timer #(.CW(CW)) u_rx_stby (
    .clk(clk), .rst(rst), .fs(rx_fs), .limit(limit), .standby(rx_standby)
  );

endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk (
  input logic clk,
  input logic rst,
  input logic fixed_mode,
  input logic tx_fs,
  input logic rx_fs,
  input logic tx_oe,
  input logic rx_valid,
  input logic rx_sig,
  input logic tx_standby,
  input logic rx_standby
);

  p_oe_needs_fs_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe) |-> $past(tx_fs));

  p_oe_off_var_r4: assert property (@(posedge clk) disable iff (rst)
    (!fixed_mode && !tx_fs) |=> !tx_oe);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_no_sig_var_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !$past(fixed_mode)) |-> !rx_sig);

  p_tx_stby_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_standby && !tx_fs) |=> tx_standby);

  p_rx_stby_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_standby && !rx_fs) |=> rx_standby);

  p_tx_stby_exit_r9: assert property (@(posedge clk) disable iff (rst)
    tx_fs |=> !tx_standby);

  p_rx_stby_exit_r9: assert property (@(posedge clk) disable iff (rst)
    rx_fs |=> !rx_standby);

endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
  .clk(clk), .rst(rst), .fixed_mode(fixed_mode), .tx_fs(tx_fs), .rx_fs(rx_fs),
  .tx_oe(tx_oe), .rx_valid(rx_valid), .rx_sig(rx_sig),
  .tx_standby(tx_standby), .rx_standby(rx_standby)
);

// File: tb/tb_pcm_voice_port.sv
`timescale 1ns/1ps
module tb_pcm_voice_port;
  localparam int L0 = 20, L1 = 21, L2 = 27;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fixed_mode = 1'b1;
  logic [1:0] clk_sel = 2'd0;
  logic       tx_dclk = 1'b0, rx_dclk = 1'b0;
  logic       tx_fs = 1'b0, rx_fs = 1'b0;
  logic [7:0] tx_sample = '0;
  logic       loop = 1'b1, rx_drv = 1'b0;
  logic       rx_sd;
  logic       tx_sd, tx_oe, rx_valid, rx_sig, tx_standby, rx_standby;
  logic [7:0] rx_sample;

  int checks = 0, errors = 0;
  int nvalid = 0;
  logic [7:0] last_data = '0;
  logic       last_sig = 1'b0;

  assign rx_sd = loop ? tx_sd : rx_drv;

  always #2.5 clk = ~clk;

  pcm_voice_port #(.W(8), .LIM_1536(L0), .LIM_1544(L1), .LIM_2048(L2)) dut (
    .clk(clk), .rst(rst), .fixed_mode(fixed_mode), .clk_sel(clk_sel),
    .tx_dclk(tx_dclk), .rx_dclk(rx_dclk), .tx_fs(tx_fs), .rx_fs(rx_fs),
    .tx_sample(tx_sample), .rx_sd(rx_sd), .tx_sd(tx_sd), .tx_oe(tx_oe),
    .rx_sample(rx_sample), .rx_valid(rx_valid), .rx_sig(rx_sig),
    .tx_standby(tx_standby), .rx_standby(rx_standby)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      nvalid    <= nvalid + 1;
      last_data <= rx_sample;
      last_sig  <= rx_sig;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 R2 R3 R7: one fixed-rate frame, looped back
  task automatic fixed_frame(input logic [7:0] v, input bit sig);
    logic [7:0] got;
    int oe_bad;
    oe_bad = 0;
    @(negedge clk);
    tx_sample = v; tx_fs = 1'b1; rx_fs = 1'b1;
    tx_dclk = ~tx_dclk; rx_dclk = ~rx_dclk;
    @(negedge clk);
    got[7] = tx_sd;
    if (!tx_oe) oe_bad++;
    tx_fs = sig; rx_fs = sig;
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      if (i == 1) begin tx_fs = 1'b0; rx_fs = 1'b0; end
      got[7-i] = tx_sd;
      if (!tx_oe) oe_bad++;
      if (rx_valid) oe_bad++;
    end
    @(negedge clk);
    if (tx_oe) oe_bad++;
    chk(got == v, "R1 tx bits", got, v);
    chk(oe_bad == 0, "R1 oe window", oe_bad, 0);
    chk(rx_valid && rx_sample == v, "R2 rx byte", {rx_valid, rx_sample}, {1'b1, v});
    chk(rx_sig == sig, "R3 signaling flag", rx_sig, sig);
  endtask

  task automatic dclk_period(input bit sample_tx, output logic bit_out, output logic oe_out);
    @(negedge clk); tx_dclk = 1'b1; rx_dclk = 1'b1;
    @(negedge clk);
    bit_out = tx_sd; oe_out = tx_oe;
    if (!sample_tx) bit_out = 1'b0;
    @(negedge clk);
    @(negedge clk); tx_dclk = 1'b0; rx_dclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // R4 R5 R6 R7: one variable-rate slot with a ninth extra edge
  task automatic var_slot(input logic [7:0] v);
    logic [7:0] got;
    logic b, o;
    int oe_bad, n0;
    oe_bad = 0;
    n0 = nvalid;
    @(negedge clk);
    tx_sample = v; tx_fs = 1'b1; rx_fs = 1'b1;
    for (int i = 0; i < 9; i++) begin
      dclk_period(1'b1, b, o);
      if (i < 8) begin got[7-i] = b; if (!o) oe_bad++; end
      else if (o) oe_bad++;
    end
    @(negedge clk); tx_fs = 1'b0; rx_fs = 1'b0;
    @(negedge clk);
    chk(got == v, "R4 tx bits", got, v);
    chk(oe_bad == 0 && !tx_oe, "R4 oe window", oe_bad, 0);
    chk(nvalid == n0 + 1 && last_data == v, "R5 rx byte", last_data, v);
    chk(last_sig == 1'b0, "R6 sig in variable mode", last_sig, 0);
  endtask

  task automatic standby_run(input logic [1:0] sel, input int lim);
    @(negedge clk);
    clk_sel = sel; tx_fs = 1'b1; rx_fs = 1'b1;
    @(negedge clk);
    chk(!tx_standby && !rx_standby, "R9 standby cleared", {tx_standby, rx_standby}, 0);
    tx_fs = 1'b0;
    repeat (lim - 1) @(negedge clk);
    chk(!tx_standby, "R8 tx not yet standby", tx_standby, 0);
    @(negedge clk);
    chk(tx_standby, "R8 tx standby at limit", tx_standby, 1);
    chk(!rx_standby, "R10 rx unaffected", rx_standby, 0);
    rx_fs = 1'b0;
    repeat (lim) @(negedge clk);
    chk(rx_standby && tx_standby, "R8 rx standby at limit", {tx_standby, rx_standby}, 3);
    tx_fs = 1'b1;
    @(negedge clk);
    chk(!tx_standby, "R9 tx exit", tx_standby, 0);
    chk(rx_standby, "R10 rx stays in standby", rx_standby, 1);
    rx_fs = 1'b1;
    @(negedge clk);
    chk(!rx_standby, "R9 rx exit", rx_standby, 0);
    tx_fs = 1'b0; rx_fs = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic b, o;
    int n0, oe_bad;
    repeat (3) @(negedge clk);
    chk({tx_sd, tx_oe, rx_valid, rx_sig, tx_standby, rx_standby, rx_sample} == '0,
        "R11 outputs in reset", {tx_sd, tx_oe, rx_valid, rx_sample}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({tx_sd, tx_oe, rx_valid, rx_sig, tx_standby, rx_standby, rx_sample} == '0,
        "R11 outputs after reset", {tx_sd, tx_oe, rx_valid, rx_sample}, 0);

    // fixed mode sweep, alternating frame types
    fixed_mode = 1'b1;
    for (int v = 0; v < 256; v++) fixed_frame(8'(v), v[0]);

    // variable mode sweep
    fixed_mode = 1'b0;
    @(negedge clk);
    for (int v = 0; v < 256; v++) var_slot(8'(255 - v));

    // R4 R5: data clock toggling with the enable low moves nothing
    n0 = nvalid; oe_bad = 0;
    for (int i = 0; i < 10; i++) begin
      dclk_period(1'b1, b, o);
      if (o) oe_bad++;
    end
    chk(oe_bad == 0, "R4 no output without enable", oe_bad, 0);
    chk(nvalid == n0, "R5 no capture without enable", nvalid, n0);

    // R5: aborted slot leaves nothing behind
    @(negedge clk); tx_sample = 8'h3C; tx_fs = 1'b1; rx_fs = 1'b1;
    for (int i = 0; i < 3; i++) dclk_period(1'b1, b, o);
    @(negedge clk); tx_fs = 1'b0; rx_fs = 1'b0;
    @(negedge clk);
    chk(nvalid == n0, "R5 aborted slot gives no byte", nvalid, n0);
    var_slot(8'hA5);

    // R8 R9 R10 per rate code
    standby_run(2'd0, L0);
    standby_run(2'd1, L1);
    standby_run(2'd2, L2);
    standby_run(2'd3, L2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule